// File: doc/BRIEF.md
# PLL Configuration and Lock Tracker

This block is the control side of a clock multiplier. Software loads one configuration word that carries a multiply factor, a divider setting and a lock-wait count, all in a single write. The block holds those fields, decides whether the multiplier path is enabled, and presents the effective multiply ratio to the analog loop, which sits outside this block.

The lock flag is not measured from the loop. It is a timeout counted in reference-clock cycles. Any write that changes the multiply factor or the divider setting clears the flag and restarts the count. A write that keeps both of those unchanged leaves the flag and the running count alone, and a new lock-wait value in such a write takes effect at once. While the path is disabled the flag stays low and the count is held at zero. An interrupt output follows the flag, gated by an enable input.

Top module: `pll_lock_tracker`

## Requirements
- R1: After reset all configuration fields are zero, and `locked`, `irq`, `pll_on` and `mult_ratio` are all zero.
- R2: A write with `cfg_we` high loads all three fields together at the next rising edge of `clk_ref`. The multiply factor is `cfg_wdata[10:0]`, the divider setting is `cfg_wdata[18:11]` and the lock-wait count is `cfg_wdata[24:19]`. Each field is visible on its own output after that edge.
- R3: `pll_on` is high exactly when both the stored multiply factor and the stored divider setting are nonzero.
- R4: `mult_ratio` equals the stored multiply factor plus one while `pll_on` is high, and zero otherwise. A factor of 2047 gives 2048.
- R5: With the path enabled, `locked` rises at the max(N,1)-th rising edge after the write that last changed the multiply factor or divider setting, where N is the lock-wait count then held.
- R6: A write that changes the multiply factor or the divider setting drives `locked` low after that edge and restarts the count from zero.
- R7: A write that keeps the multiply factor and divider setting unchanged does not clear `locked` and does not restart the count. A new lock-wait count in such a write applies immediately.
- R8: While `pll_on` is low, `locked` stays low.
- R9: `irq` is high exactly when `locked` is high and `irq_en` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 25 | Configuration word: factor, divider setting, lock-wait count |
| irq_en | input | 1 | Enable for the lock interrupt |
| cfg_mul | output | 11 | Stored multiply factor |
| cfg_div | output | 8 | Stored divider setting |
| cfg_lockcnt | output | 6 | Stored lock-wait count |
| pll_on | output | 1 | Multiplier path enabled |
| mult_ratio | output | 12 | Effective multiply ratio, zero when disabled |
| locked | output | 1 | Lock status |
| irq | output | 1 | Lock interrupt |

## Verification
The stored fields, `pll_on` and `mult_ratio` are due one edge after the write. `locked` is due max(N,1) edges after the last write that changed the factor or divider, and it clears one edge after such a write. `irq` follows `locked` and `irq_en` in the same cycle with no register between them. The bench drives inputs on the falling edge and advances a cycle-level reference model at each rising edge. It compares every output at the following falling edge, so every result is checked exactly in the cycle it becomes due.

// File: rtl/pllt_pkg.sv
package pllt_pkg;
   localparam int DEF_MUL_W = 11;
   localparam int DEF_DIV_W = 8;
   localparam int DEF_CNT_W = 6;

   typedef enum logic {
      RATIO_COMB = 1'b0,
      RATIO_REG  = 1'b1
   } ratio_mode_e;
endpackage

// File: rtl/pllt_cfg_reg.sv
module pllt_cfg_reg #(
   parameter int MUL_W = pllt_pkg::DEF_MUL_W,
   parameter int DIV_W = pllt_pkg::DEF_DIV_W,
   parameter int CNT_W = pllt_pkg::DEF_CNT_W,
   localparam int WORD_W = MUL_W + DIV_W + CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WORD_W-1:0] wdata,
   output logic [MUL_W-1:0] mul_q,
   output logic [DIV_W-1:0] div_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             path_chg,
   output logic             on_next,
   output logic [CNT_W-1:0] cnt_next,
   output logic             on_q
);
   logic [MUL_W-1:0] w_mul;
   logic [DIV_W-1:0] w_div;
   logic [CNT_W-1:0] w_cnt;

   assign w_mul = wdata[MUL_W-1:0];
   assign w_div = wdata[MUL_W +: DIV_W];
   assign w_cnt = wdata[MUL_W+DIV_W +: CNT_W];

   always_comb begin
      path_chg = we && ((w_mul != mul_q) || (w_div != div_q));
      on_next  = we ? ((w_mul != '0) && (w_div != '0)) : on_q;
      cnt_next = we ? w_cnt : cnt_q;
   end

   assign on_q = (mul_q != '0) && (div_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mul_q <= '0;
         div_q <= '0;
         cnt_q <= '0;
      end else if (we) begin
         mul_q <= w_mul;
         div_q <= w_div;
         cnt_q <= w_cnt;
      end
   end
endmodule

// File: rtl/pllt_lock_ctr.sv
module pllt_lock_ctr #(
   parameter int CNT_W = pllt_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             enable,
   input  logic [CNT_W-1:0] target,
   output logic             locked
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_inc;
   logic [CNT_W:0]   goal;

   always_comb begin
      cnt_inc = {1'b0, cnt_q} + 1'b1;
      goal    = (target == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, target};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         locked <= 1'b0;
      end else if (restart || !enable) begin
         cnt_q  <= '0;
         locked <= 1'b0;
      end else if (!locked) begin
         cnt_q <= cnt_inc[CNT_W-1:0];
         if (cnt_inc >= goal) locked <= 1'b1;
      end
   end
endmodule

// File: rtl/pllt_ratio.sv
module pllt_ratio #(
   parameter int MUL_W = pllt_pkg::DEF_MUL_W,
   parameter pllt_pkg::ratio_mode_e MODE = pllt_pkg::RATIO_COMB
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           on,
   input  logic [MUL_W-1:0] mul,
   output logic [MUL_W:0] ratio
);
   logic [MUL_W:0] ratio_d;

   assign ratio_d = on ? ({1'b0, mul} + 1'b1) : '0;

   generate
      if (MODE == pllt_pkg::RATIO_REG) begin : g_reg
         logic [MUL_W:0] ratio_q;
         always_ff @(posedge clk) begin
            if (!rst_n) ratio_q <= '0;
            else        ratio_q <= ratio_d;
         end
         assign ratio = ratio_q;
      end else begin : g_comb
         assign ratio = ratio_d;
      end
   endgenerate
endmodule

// File: rtl/pll_lock_tracker.sv
module pll_lock_tracker #(
   parameter int MUL_W = pllt_pkg::DEF_MUL_W,
   parameter int DIV_W = pllt_pkg::DEF_DIV_W,
   parameter int CNT_W = pllt_pkg::DEF_CNT_W,
   parameter pllt_pkg::ratio_mode_e RATIO_MODE = pllt_pkg::RATIO_COMB,
   localparam int WORD_W = MUL_W + DIV_W + CNT_W
) (
   input  logic              clk_ref,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              irq_en,
   output logic [MUL_W-1:0]  cfg_mul,
   output logic [DIV_W-1:0]  cfg_div,
   output logic [CNT_W-1:0]  cfg_lockcnt,
   output logic              pll_on,
   output logic [MUL_W:0]    mult_ratio,
   output logic              locked,
   output logic              irq
);
   generate
      if (MUL_W < 1 || MUL_W > 16) begin : g_bad_mul
         $error("pll_lock_tracker: MUL_W out of range");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("pll_lock_tracker: DIV_W out of range");
      end
      if (CNT_W < 1 || CNT_W > 24) begin : g_bad_cnt
         $error("pll_lock_tracker: CNT_W out of range");
      end
   endgenerate

   logic             path_chg;
   logic             on_next;
   logic [CNT_W-1:0] cnt_next;

   pllt_cfg_reg #(.MUL_W(MUL_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_cfg (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .wdata    (cfg_wdata),
      .mul_q    (cfg_mul),
      .div_q    (cfg_div),
      .cnt_q    (cfg_lockcnt),
      .path_chg (path_chg),
      .on_next  (on_next),
      .cnt_next (cnt_next),
      .on_q     (pll_on)
   );

   pllt_lock_ctr #(.CNT_W(CNT_W)) u_lock (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .restart (path_chg),
      .enable  (on_next),
      .target  (cnt_next),
      .locked  (locked)
   );

   pllt_ratio #(.MUL_W(MUL_W), .MODE(RATIO_MODE)) u_ratio (
      .clk   (clk_ref),
      .rst_n (rst_n),
      .on    (pll_on),
      .mul   (cfg_mul),
      .ratio (mult_ratio)
   );

   assign irq = locked & irq_en;
endmodule

// File: rtl/pll_lock_tracker_chk.sv
module pll_lock_tracker_chk #(
   parameter int MUL_W = pllt_pkg::DEF_MUL_W,
   parameter int DIV_W = pllt_pkg::DEF_DIV_W,
   parameter int CNT_W = pllt_pkg::DEF_CNT_W,
   parameter pllt_pkg::ratio_mode_e RATIO_MODE = pllt_pkg::RATIO_COMB,
   localparam int WORD_W = MUL_W + DIV_W + CNT_W
) (
   input logic              clk_ref,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [WORD_W-1:0] cfg_wdata,
   input logic              irq_en,
   input logic [MUL_W-1:0]  cfg_mul,
   input logic [DIV_W-1:0]  cfg_div,
   input logic [CNT_W-1:0]  cfg_lockcnt,
   input logic              pll_on,
   input logic [MUL_W:0]    mult_ratio,
   input logic              locked,
   input logic              irq
);
   logic [MUL_W-1:0] w_mul;
   logic [DIV_W-1:0] w_div;
   logic             w_chg;
   logic             w_same;
   logic [CNT_W:0]   since;

   assign w_mul  = cfg_wdata[MUL_W-1:0];
   assign w_div  = cfg_wdata[MUL_W +: DIV_W];
   assign w_chg  = cfg_we && ((w_mul != cfg_mul) || (w_div != cfg_div));
   assign w_same = cfg_we && (w_mul == cfg_mul) && (w_div == cfg_div);

   always_ff @(posedge clk_ref) begin
      if (!rst_n) since <= '0;
      else if (w_chg || (cfg_we ? (w_mul == '0 || w_div == '0) : !pll_on)) since <= '0;
      else if (since != '1) since <= since + 1'b1;
   end

   AST_WRITE_LOADS: assert property (@(posedge clk_ref) disable iff (!rst_n)
      cfg_we |=> (cfg_mul == $past(w_mul)) && (cfg_div == $past(w_div))); // R2

   AST_OFF_NO_LOCK: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !pll_on |-> !locked); // R8

   AST_CHANGE_DROPS: assert property (@(posedge clk_ref) disable iff (!rst_n)
      w_chg |=> !locked); // R6

   AST_SAME_KEEPS: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (w_same && locked) |=> locked); // R7

   AST_NOT_EARLY: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(locked) |-> (since != '0) && (since >= {1'b0, cfg_lockcnt})); // R5

   AST_IRQ_NEEDS_LOCK: assert property (@(posedge clk_ref) disable iff (!rst_n)
      irq |-> (locked && irq_en)); // R9

   generate
      if (RATIO_MODE == pllt_pkg::RATIO_COMB) begin : g_ratio_chk
         AST_RATIO_VALUE: assert property (@(posedge clk_ref) disable iff (!rst_n)
            pll_on |-> (mult_ratio == {1'b0, cfg_mul} + 1'b1)); // R4
      end
   endgenerate
endmodule

bind pll_lock_tracker pll_lock_tracker_chk #(
   .MUL_W(MUL_W), .DIV_W(DIV_W), .CNT_W(CNT_W), .RATIO_MODE(RATIO_MODE)
) u_chk (.*);

// File: tb/pll_lock_tracker_test.sv
module pll_lock_tracker_test;
   logic        clk_ref = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [24:0] cfg_wdata;
   logic        irq_en;
   logic [10:0] cfg_mul;
   logic [7:0]  cfg_div;
   logic [5:0]  cfg_lockcnt;
   logic        pll_on;
   logic [11:0] mult_ratio;
   logic        locked;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   int m_mul, m_div, m_cnt, m_since;
   bit m_lock;
   string lock_tag;

   always #4 clk_ref = ~clk_ref;

   pll_lock_tracker uut (.*);

   function automatic logic [24:0] pack(int mul, int dv, int cnt);
      return {cnt[5:0], dv[7:0], mul[10:0]};
   endfunction

   function automatic int exp_ratio(int mul, int dv);
      return (mul != 0 && dv != 0) ? mul + 1 : 0;
   endfunction

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(bit we, logic [24:0] d, bit ie);
      bit on, chg;
      int nm, nd, goal;
      cfg_we = we; cfg_wdata = d; irq_en = ie;
      @(posedge clk_ref);
      nm = int'(d[10:0]); nd = int'(d[18:11]);
      chg = we && (nm != m_mul || nd != m_div);
      if (we) begin m_mul = nm; m_div = nd; m_cnt = int'(d[24:19]); end
      on = (m_mul != 0) && (m_div != 0);
      if (!on)            lock_tag = "R8";
      else if (chg)       lock_tag = "R6";
      else if (we)        lock_tag = "R7";
      else                lock_tag = "R5";
      if (chg || !on) begin
         m_since = 0; m_lock = 0;
      end else if (!m_lock) begin
         m_since++;
         goal = (m_cnt == 0) ? 1 : m_cnt;
         if (m_since >= goal) m_lock = 1;
      end
      @(negedge clk_ref);
      chk("R2 mul", int'(cfg_mul), m_mul);
      chk("R2 div", int'(cfg_div), m_div);
      chk("R2 lockcnt", int'(cfg_lockcnt), m_cnt);
      chk("R3 pll_on", int'(pll_on), int'(on));
      chk("R4 ratio", int'(mult_ratio), exp_ratio(m_mul, m_div));
      chk({lock_tag, " locked"}, int'(locked), int'(m_lock));
      chk("R9 irq", int'(irq), int'(m_lock && ie));
   endtask

   task automatic idle(int n, bit ie);
      for (int i = 0; i < n; i++) step(1'b0, cfg_wdata, ie);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1a2b3c4d));
      rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; irq_en = 1'b1;
      m_mul = 0; m_div = 0; m_cnt = 0; m_since = 0; m_lock = 0;
      repeat (3) @(posedge clk_ref);
      @(negedge clk_ref);
      // R1: reset state
      chk("R1 mul", int'(cfg_mul), 0);
      chk("R1 div", int'(cfg_div), 0);
      chk("R1 lockcnt", int'(cfg_lockcnt), 0);
      chk("R1 locked", int'(locked), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 pll_on", int'(pll_on), 0);
      chk("R1 ratio", int'(mult_ratio), 0);
      rst_n = 1'b1;

      // R5: lock after exactly four edges
      step(1'b1, pack(5, 1, 4), 1'b1);
      idle(5, 1'b1);
      // R7: identical factor and divider, new count, lock kept
      step(1'b1, pack(5, 1, 30), 1'b1);
      idle(2, 1'b0);
      // R6: divider change drops lock
      step(1'b1, pack(5, 2, 2), 1'b1);
      idle(3, 1'b1);
      // R8: factor zero disables the path
      step(1'b1, pack(0, 1, 1), 1'b1);
      idle(3, 1'b1);
      // R8: divider zero disables the path
      step(1'b1, pack(9, 0, 1), 1'b1);
      idle(3, 1'b1);
      // R5: count zero locks after one edge; R4: largest factor
      step(1'b1, pack(2047, 1, 0), 1'b1);
      idle(2, 1'b1);
      // R7: unchanged write while counting keeps counting, lower count applies
      step(1'b1, pack(3, 1, 20), 1'b1);
      idle(5, 1'b1);
      step(1'b1, pack(3, 1, 4), 1'b1);
      idle(3, 1'b1);
      // R5: largest count
      step(1'b1, pack(4, 1, 63), 1'b1);
      idle(66, 1'b1);

      for (int i = 0; i < 4000; i++) begin
         int sel, mul, dv, cnt;
         if ($urandom_range(7) == 0) begin
            sel = int'($urandom_range(4));
            mul = (sel == 0) ? 0 : (sel == 1) ? 2047 : (sel == 2) ? m_mul : int'($urandom_range(6));
            dv  = (sel == 3) ? m_div : int'($urandom_range(2));
            cnt = int'($urandom_range(12));
            step(1'b1, pack(mul, dv, cnt), 1'($urandom_range(1)));
         end else begin
            step(1'b0, pack(int'($urandom_range(2047)), 1, 0), 1'($urandom_range(1)));
         end
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule